// File: doc/BRIEF.md
# Dual-Channel Counter Interrupt Aggregator

This block collects the event sources of a two-channel incremental counter and turns them into six interrupt request lines. The sources are a zero-mark pulse per channel, four special input signals per channel (detected on their rising edges after synchronisation), an overflow pulse per channel and a comparator-match pulse per channel. That makes fourteen sub-sources. Each one has its own sticky pending flag.

A flag is set by its event and stays set until software writes a one to that flag's bit in the clear register. Two status registers report every flag whether its interrupt is enabled or not. A control register and a mask register hold the enables that gate the flags onto the outputs. Each interrupt line is a registered OR of the enabled flags in its group.

Software reaches the registers through a simple synchronous bus: a write strobe, an address, write data, and read data that follows the address combinationally.

Top module: `cnt_irq_hub`

## Requirements
- R1: After reset, every flag, every enable bit and all six `irq` outputs are zero, and both status registers read 0x0000.
- R2: A high level on `zmark[c]` at a clock edge sets the zero-mark flag of channel c at that edge. Status register 0 (address 2) shows channel 0 in bit 0 and channel 1 in bit 1.
- R3: `spec_in[4c+j]` is special signal j of channel c, with j from 0 to 3. Each input passes through SYNC_STAGES synchronizer flops and then a rising-edge detector. The flag is set at the (SYNC_STAGES+1)-th edge after the input rises, and a level held high sets it only once. Signals 0 and 2 show in status register 0 (address 2) at bits 4 and 5 for channel 0 and bits 6 and 7 for channel 1. Signals 1 and 3 show in status register 2 (address 3) at bits 8c+0 and 8c+1.
- R4: A high level on `ovf[c]` sets the overflow flag, shown in status register 2 at bit 8c+2. A high level on `cmp_hit[c]` sets the compare flag, shown at bit 8c+3.
- R5: Flags are sticky. A write to address 4 clears each flag whose clear bit is one, at the edge of the write. The clear bits for channel c are: zero mark 8c+0, special 0 at 8c+1, special 2 at 8c+2, special 1 at 8c+3, special 3 at 8c+4, overflow 8c+5, compare 8c+6. Zero bits in the write leave their flags untouched.
- R6: If a flag's event and a clear of that flag fall in the same cycle, the flag ends up set.
- R7: The status registers show pending flags whatever the enable settings.
- R8: `irq[0]` is set one edge after (channel 0 zero-mark flag AND control bit 7) OR (channel 1 zero-mark flag AND control bit 6). The control register is at address 0.
- R9: `irq[1]` is set one edge after any of the four flags for special signals 0 and 2 is set while control bit 5 is one. Control bit 5 is the single enable shared by all four.
- R10: `irq[2+c]` is the registered OR of the special-1, special-3 and overflow flags of channel c. Each flag is gated by its own bit of the mask register (address 1): bits 8c+0, 8c+1 and 8c+2 respectively.
- R11: `irq[4+c]` is the registered compare flag of channel c, gated by mask bit 8c+3.
- R12: Reading address 0 returns only control bits 7:5, and address 1 returns only mask bits 0-3 and 8-11. Address 4 and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| zmark | input | 2 | Zero-mark pulse per channel |
| spec_in | input | 8 | Special signals, four per channel, asynchronous |
| ovf | input | 2 | Counter overflow pulse per channel |
| cmp_hit | input | 2 | Comparator match pulse per channel |
| irq | output | 6 | Interrupt request lines |

## Verification
The bench builds the block with its defaults: ADDR_W of 4 and a two-stage synchronizer. With these values the whole source space is small enough to sweep completely. The sweep covers all fourteen sub-sources, each with its own enable set alone and with every other enable set. The expected status bit, interrupt line and enable position are all derived arithmetically from the channel and source index. The two-stage setting fixes the special-signal latency at three edges, which the bench probes on both sides of the edge where the flag is expected.

// File: rtl/cnt_irq_hub.sv
module cnt_irq_hub #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [1:0]        zmark,
  input  logic [7:0]        spec_in,
  input  logic [1:0]        ovf,
  input  logic [1:0]        cmp_hit,
  output logic [5:0]        irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ST0  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ST2  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(4);
  localparam logic [15:0] FLAG_MASK = 16'h7F7F;
  localparam logic [15:0] IMASK_IMP = 16'h0F0F;
  localparam logic [7:0]  CTRL_IMP  = 8'hE0;

  logic [SYNC_STAGES:0][7:0] sp_pipe;
  logic [7:0]  sp_rise;
  logic [15:0] ev, en, act, flags, clr, imask;
  logic [7:0]  ctrl0;
  logic [5:0]  irq_d;

  always_ff @(posedge clk) begin
    if (!rst_n) sp_pipe <= '0;
    else        sp_pipe <= {sp_pipe[SYNC_STAGES-1:0], spec_in};
  end

  assign sp_rise = sp_pipe[SYNC_STAGES-1] & ~sp_pipe[SYNC_STAGES];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam int B = c * 8;
    localparam int S = c * 4;
    assign ev[B+0] = zmark[c];
    assign ev[B+1] = sp_rise[S+0];
    assign ev[B+2] = sp_rise[S+2];
    assign ev[B+3] = sp_rise[S+1];
    assign ev[B+4] = sp_rise[S+3];
    assign ev[B+5] = ovf[c];
    assign ev[B+6] = cmp_hit[c];
    assign ev[B+7] = 1'b0;

    assign en[B+0] = ctrl0[7-c];
    assign en[B+1] = ctrl0[5];
    assign en[B+2] = ctrl0[5];
    assign en[B+3] = imask[B+0];
    assign en[B+4] = imask[B+1];
    assign en[B+5] = imask[B+2];
    assign en[B+6] = imask[B+3];
    assign en[B+7] = 1'b0;
  end

  assign clr = (wr_en && addr == A_CLR) ? (wdata & FLAG_MASK) : '0;
  assign act = flags & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      ctrl0 <= '0;
      imask <= '0;
      irq   <= '0;
    end else begin
      flags <= (flags & ~clr) | ev;
      if (wr_en && addr == A_CTRL) ctrl0 <= wdata[7:0] & CTRL_IMP;
      if (wr_en && addr == A_MASK) imask <= wdata & IMASK_IMP;
      irq   <= irq_d;
    end
  end

  assign irq_d[0] = act[0] | act[8];
  assign irq_d[1] = act[1] | act[2] | act[9] | act[10];
  assign irq_d[2] = |act[5:3];
  assign irq_d[3] = |act[13:11];
  assign irq_d[4] = act[6];
  assign irq_d[5] = act[14];

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {8'h00, ctrl0};
      A_MASK:  rdata = imask;
      A_ST0:   rdata = {8'h00, flags[10], flags[9], flags[2], flags[1],
                        2'b00, flags[8], flags[0]};
      A_ST2:   rdata = {4'h0, flags[14], flags[13:11], 4'h0, flags[6], flags[5:3]};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/cnt_irq_hub_chk.sv
module cnt_irq_hub_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic [1:0]        zmark,
  input logic [1:0]        ovf,
  input logic [1:0]        cmp_hit,
  input logic [15:0]       flags,
  input logic [7:0]        ctrl0,
  input logic [15:0]       imask,
  input logic [5:0]        irq
);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(4);
  logic clr_wr;
  assign clr_wr = wr_en && addr == A_CLR;

  assert_zmark_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    zmark[0] |=> flags[0]);

  assert_ovf_cmp_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[1] && cmp_hit[1]) |=> (flags[13] && flags[14]));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flags & $past(flags)) == $past(flags)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wdata[6] && !cmp_hit[0]) |=> !flags[6]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wdata[8] && zmark[1]) |=> flags[8]);

  assert_irq1_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl0[5] |=> !irq[1]);

  assert_irq4_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[6] && imask[3]) |=> irq[4]);

  assert_irq4_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[6] && imask[3]) |=> !irq[4]);
endmodule

bind cnt_irq_hub cnt_irq_hub_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .zmark(zmark), .ovf(ovf), .cmp_hit(cmp_hit), .flags(flags),
  .ctrl0(ctrl0), .imask(imask), .irq(irq)
);

// File: tb/test_cnt_irq_hub.sv
module test_cnt_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  zmark = '0, ovf = '0, cmp_hit = '0;
  logic [7:0]  spec_in = '0;
  logic [5:0]  irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cnt_irq_hub i_cnt_irq_hub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .zmark(zmark), .spec_in(spec_in), .ovf(ovf),
    .cmp_hit(cmp_hit), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic fire(int s);
    int ch, k, si;
    ch = s / 7; k = s % 7;
    @(negedge clk);
    if (k >= 1 && k <= 4) begin
      si = ch*4 + ((k == 1) ? 0 : (k == 2) ? 2 : (k == 3) ? 1 : 3);
      spec_in[si] = 1'b1;
      repeat (4) @(negedge clk);
      spec_in[si] = 1'b0;
      @(negedge clk);
    end else begin
      if (k == 0) zmark[ch] = 1'b1;
      if (k == 5) ovf[ch] = 1'b1;
      if (k == 6) cmp_hit[ch] = 1'b1;
      @(negedge clk);
      zmark = '0; ovf = '0; cmp_hit = '0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v0, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2, v0); chk("R1 status0", v0, 0);
    rd(3, v2); chk("R1 status2", v2, 0);
    rd(0, v0); chk("R1 ctrl", v0, 0);
    rd(1, v0); chk("R1 mask", v0, 0);
    chk("R1 irq", irq, 0);

    wr(0, 16'hFFFF); rd(0, v0); chk("R12 ctrl readback", v0, 16'h00E0);
    wr(1, 16'hFFFF); rd(1, v0); chk("R12 mask readback", v0, 16'h0F0F);
    rd(4, v0); chk("R12 clear reads zero", v0, 0);
    rd(7, v0); chk("R12 unused reads zero", v0, 0);

    // Full sweep over the fourteen sub-sources, enabled alone / everything else enabled
    for (int s = 0; s < 14; s++) begin
      for (int en = 0; en < 2; en++) begin
        int ch, k, cb, irqn, eaddr, ebit, saddr, sbit;
        string rs, ri;
        logic [15:0] e0, e2, ea;
        ch = s / 7; k = s % 7; cb = ch*8 + k;
        if (k == 0) begin
          saddr = 2; sbit = ch; irqn = 0; eaddr = 0; ebit = 7 - ch; rs = "R2"; ri = "R8";
        end else if (k <= 2) begin
          saddr = 2; sbit = 4 + ch*2 + k - 1; irqn = 1; eaddr = 0; ebit = 5; rs = "R3"; ri = "R9";
        end else if (k <= 5) begin
          saddr = 3; sbit = ch*8 + k - 3; irqn = 2 + ch; eaddr = 1; ebit = ch*8 + k - 3;
          rs = (k == 5) ? "R4" : "R3"; ri = "R10";
        end else begin
          saddr = 3; sbit = ch*8 + 3; irqn = 4 + ch; eaddr = 1; ebit = ch*8 + 3; rs = "R4"; ri = "R11";
        end
        if (en == 0) rs = "R7";
        ea = (en == 1) ? (16'h1 << ebit) : (16'hFFFF & ~(16'h1 << ebit));
        wr(eaddr[3:0], ea);
        wr((eaddr == 0) ? 4'd1 : 4'd0, (en == 1) ? 16'h0000 : 16'hFFFF);
        e0 = (saddr == 2) ? (16'h1 << sbit) : 16'h0;
        e2 = (saddr == 3) ? (16'h1 << sbit) : 16'h0;
        fire(s);
        rd(2, v0); chk({rs, " status0"}, v0, e0);
        rd(3, v2); chk({rs, " status2"}, v2, e2);
        chk({ri, " irq"}, irq, (en == 1) ? (32'h1 << irqn) : 32'h0);
        wr(4, 16'hFFFF & ~(16'h1 << cb));
        rd(2, v0); chk("R5 zero bits keep status0", v0, e0);
        rd(3, v2); chk("R5 zero bits keep status2", v2, e2);
        wr(4, 16'h1 << cb);
        @(negedge clk);
        rd(2, v0); chk("R5 cleared status0", v0, 0);
        rd(3, v2); chk("R5 cleared status2", v2, 0);
        chk("R5 irq after clear", irq, 0);
      end
    end

    // R3: synchronizer latency and single set per held level
    wr(0, 16'h0000); wr(1, 16'h0000);
    @(negedge clk); spec_in[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3, v2); chk("R3 not yet after two edges", v2, 0);
    @(negedge clk);
    rd(3, v2); chk("R3 set on third edge", v2, 16'h0100);
    wr(4, 16'h0800);
    repeat (4) @(negedge clk);
    rd(3, v2); chk("R3 held level sets once", v2, 0);
    spec_in[5] = 1'b0;
    repeat (4) @(negedge clk);

    // R6: event and clear in the same cycle
    @(negedge clk); wr_en = 1; addr = 4; wdata = 16'h0001; zmark[0] = 1'b1;
    @(negedge clk); wr_en = 0; wdata = '0; zmark = '0;
    rd(2, v0); chk("R6 set wins over clear", v0, 16'h0001);
    wr(4, 16'hFFFF);

    // All sources at once, all enables on
    wr(0, 16'h00E0); wr(1, 16'h0F0F);
    @(negedge clk); zmark = 2'b11; ovf = 2'b11; cmp_hit = 2'b11; spec_in = 8'hFF;
    @(negedge clk); zmark = '0; ovf = '0; cmp_hit = '0;
    repeat (4) @(negedge clk);
    rd(2, v0); chk("R2 R3 all status0", v0, 16'h00F3);
    rd(3, v2); chk("R4 all status2", v2, 16'h0F0F);
    chk("R10 all irq", irq, 6'h3F);
    spec_in = '0;
    wr(4, 16'hFFFF); @(negedge clk);
    rd(2, v0); chk("R5 clear all status0", v0, 0);
    rd(3, v2); chk("R5 clear all status2", v2, 0);
    chk("R5 clear all irq", irq, 0);

    finish_run();
  end
endmodule